// File: doc/BRIEF.md
# Two-Wide Next Fetch Address Selector

This block picks the address the instruction front end fetches from next. It is built for a front end that fetches two instructions in each cycle from one aligned fetch address. For each of the two fetched slots it receives a branch class and a predicted-taken flag. It also receives three predicted targets:

- a per-slot target from the branch target buffer;
- a return target from the return address stack;
- a target from the indirect-jump predictor.

A backend port carries a resolved redirect address when a misprediction is found.

Each cycle the block decides the next fetch address. The options are the sequential address, a predicted target of the earliest predicted-taken slot, or the backend redirect. It also produces a slot-valid mask. The mask marks which of the two instructions fetched this cycle lie on the predicted path.

The current fetch address is held in a register. That register loads the chosen next address on every clock, so the front end never stalls inside this block.

Top module: `npc_sel`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` holds `RESET_PC` (default 0x0000_1000). After `rst_n` rises, the first fetch comes from that address.
- R2: If no redirect is present and neither slot is a predicted-taken control transfer, `next_pc` equals `fetch_pc + 8` and `slot_valid` is 2'b11.
- R3: The slot class is encoded as 0 = not a branch, 1 = direct transfer, 2 = return, 3 = indirect jump. A taken slot of class 1 uses its own branch target buffer target. Class 2 uses `ras_tgt`, and class 3 uses `ind_tgt`.
- R4: If slot 0 is predicted taken, its target is chosen. All of slot 1's inputs then have no effect on `next_pc`.
- R5: If slot 0 is predicted taken and no redirect is present, `slot_valid` is 2'b01. Bit 0 is slot 0 and bit 1 is slot 1.
- R6: If only slot 1 is predicted taken and no redirect is present, `next_pc` is slot 1's target and `slot_valid` is 2'b11.
- R7: A slot of class 0 is treated as not taken, even when its taken flag is high.
- R8: If `redir_valid` is high, `next_pc` equals `redir_pc` whatever the slot inputs are, and `slot_valid` is 2'b00.
- R9: Outside reset, `fetch_pc` takes the value `next_pc` had in the previous cycle, on every clock edge.
- R10: `next_pc` and `slot_valid` follow the current cycle's inputs with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_kind | input | 2 | Branch class of slot 0 |
| s0_taken | input | 1 | Slot 0 predicted taken |
| s0_btb | input | AW | Branch target buffer target for slot 0 |
| s1_kind | input | 2 | Branch class of slot 1 |
| s1_taken | input | 1 | Slot 1 predicted taken |
| s1_btb | input | AW | Branch target buffer target for slot 1 |
| ras_tgt | input | AW | Return address stack target |
| ind_tgt | input | AW | Indirect predictor target |
| redir_valid | input | 1 | Backend redirect present |
| redir_pc | input | AW | Resolved redirect address |
| fetch_pc | output | AW | Address fetched this cycle |
| next_pc | output | AW | Address to fetch next cycle |
| slot_valid | output | 2 | Slots of this fetch on the predicted path |

## Verification
The only state in the block is the fetch address register. If that register goes wrong, `fetch_pc` shows it at the very next edge. The error then spreads into `next_pc`, because every sequential step is `fetch_pc + 8` and the offset carries forward.

A wrong priority or a wrong class decode never lands in a register before it appears at the ports. It shows at once on `next_pc` or `slot_valid` in the same cycle, and on `fetch_pc` one edge later. The bench therefore compares all three outputs against a behavioural model in every cycle, so a fault is reported in the cycle it first appears.

// File: rtl/npc_sel.sv
module npc_sel #(
  parameter int AW = 32,
  parameter int INSN_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    s0_kind,
  input  logic          s0_taken,
  input  logic [AW-1:0] s0_btb,
  input  logic [1:0]    s1_kind,
  input  logic          s1_taken,
  input  logic [AW-1:0] s1_btb,
  input  logic [AW-1:0] ras_tgt,
  input  logic [AW-1:0] ind_tgt,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_pc,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] next_pc,
  output logic [1:0]    slot_valid
);
  localparam logic [AW-1:0] STEP = AW'(2 * INSN_BYTES);
  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_RET  = 2'd2;
  localparam logic [1:0] K_IND  = 2'd3;

  logic          tk0, tk1;
  logic [AW-1:0] tgt0, tgt1;

  assign tk0 = s0_taken && (s0_kind != K_NONE);
  assign tk1 = s1_taken && (s1_kind != K_NONE);

  assign tgt0 = (s0_kind == K_RET) ? ras_tgt :
                (s0_kind == K_IND) ? ind_tgt : s0_btb;
  assign tgt1 = (s1_kind == K_RET) ? ras_tgt :
                (s1_kind == K_IND) ? ind_tgt : s1_btb;

  assign next_pc = redir_valid ? redir_pc :
                   tk0         ? tgt0 :
                   tk1         ? tgt1 : fetch_pc + STEP;

  assign slot_valid = redir_valid ? 2'b00 :
                      tk0         ? 2'b01 : 2'b11;

  always_ff @(posedge clk) begin
    if (!rst_n) fetch_pc <= RESET_PC;
    else        fetch_pc <= next_pc;
  end
endmodule

// File: rtl/npc_sel_chk.sv
module npc_sel_chk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] STEP = 8,
  parameter logic [AW-1:0] RESET_PC = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    s0_kind,
  input logic          s0_taken,
  input logic [1:0]    s1_kind,
  input logic          s1_taken,
  input logic [AW-1:0] s1_btb,
  input logic [AW-1:0] ras_tgt,
  input logic          redir_valid,
  input logic [AW-1:0] redir_pc,
  input logic [AW-1:0] fetch_pc,
  input logic [AW-1:0] next_pc,
  input logic [1:0]    slot_valid
);
  logic live0, live1;
  assign live0 = s0_taken && s0_kind != 2'd0;
  assign live1 = s1_taken && s1_kind != 2'd0;

  p_reset_hold_r1: assert property (@(posedge clk)
    !rst_n |=> fetch_pc == RESET_PC);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && !live0 && !live1) |=> fetch_pc == $past(fetch_pc) + STEP);

  p_ret_slot1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && !live0 && live1 && s1_kind == 2'd2) |=> fetch_pc == $past(ras_tgt));

  p_first_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && live0) |-> slot_valid == 2'b01);

  p_slot1_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && !live0 && live1 && s1_kind == 2'd1) |=>
      (fetch_pc == $past(s1_btb) && $past(slot_valid) == 2'b11));

  p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (fetch_pc == $past(redir_pc) && $past(slot_valid) == 2'b00));

  p_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> fetch_pc == $past(next_pc));
endmodule

bind npc_sel npc_sel_chk #(.AW(AW), .STEP(STEP), .RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .s0_kind(s0_kind), .s0_taken(s0_taken),
  .s1_kind(s1_kind), .s1_taken(s1_taken), .s1_btb(s1_btb), .ras_tgt(ras_tgt),
  .redir_valid(redir_valid), .redir_pc(redir_pc), .fetch_pc(fetch_pc),
  .next_pc(next_pc), .slot_valid(slot_valid)
);

// File: tb/sim_npc_sel.sv
module sim_npc_sel;
  localparam int AW = 32;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic clk = 0, rst_n = 0;
  logic [1:0] s0_kind = 0, s1_kind = 0;
  logic s0_taken = 0, s1_taken = 0, redir_valid = 0;
  logic [31:0] s0_btb = 0, s1_btb = 0, ras_tgt = 0, ind_tgt = 0, redir_pc = 0;
  logic [31:0] fetch_pc, next_pc;
  logic [1:0] slot_valid;

  int checks = 0, errors = 0;
  logic [31:0] m_pc;

  always #4 clk = ~clk;

  npc_sel u0 (
    .clk(clk), .rst_n(rst_n), .s0_kind(s0_kind), .s0_taken(s0_taken), .s0_btb(s0_btb),
    .s1_kind(s1_kind), .s1_taken(s1_taken), .s1_btb(s1_btb), .ras_tgt(ras_tgt),
    .ind_tgt(ind_tgt), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .fetch_pc(fetch_pc), .next_pc(next_pc), .slot_valid(slot_valid)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: walk the slots in program order.
  task automatic model(output logic [31:0] npc, output logic [1:0] mask, output string tag);
    logic [1:0] kinds [2];
    logic tks [2];
    logic [31:0] btbs [2];
    kinds[0] = s0_kind; kinds[1] = s1_kind;
    tks[0] = s0_taken; tks[1] = s1_taken;
    btbs[0] = s0_btb; btbs[1] = s1_btb;
    npc = m_pc + 32'd8;
    mask = 2'b11;
    tag = "R2";
    if (redir_valid) begin
      npc = redir_pc; mask = 2'b00; tag = "R8";
      return;
    end
    for (int i = 0; i < 2; i++) begin
      if (kinds[i] != 0 && tks[i]) begin
        case (kinds[i])
          2'd2: npc = ras_tgt;
          2'd3: npc = ind_tgt;
          default: npc = btbs[i];
        endcase
        mask = (i == 0) ? 2'b01 : 2'b11;
        tag = (i == 0) ? "R4_R5" : "R6";
        return;
      end
    end
    if ((s0_taken && s0_kind == 0) || (s1_taken && s1_kind == 0)) tag = "R7";
  endtask

  task automatic step();
    logic [31:0] enpc;
    logic [1:0] emask;
    string tag;
    #1;
    model(enpc, emask, tag);
    check({tag, "_R10 next_pc"}, next_pc, enpc);
    check({tag, " slot_valid"}, {30'd0, slot_valid}, {30'd0, emask});
    check("R9 fetch_pc", fetch_pc, m_pc);
    @(posedge clk);
    m_pc = enpc;
    @(negedge clk);
  endtask

  task automatic drive(logic [1:0] k0, logic t0, logic [1:0] k1, logic t1, logic rv);
    s0_kind = k0; s0_taken = t0; s1_kind = k1; s1_taken = t1; redir_valid = rv;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    s0_btb = 32'h0000_2000; s1_btb = 32'h0000_3000;
    ras_tgt = 32'h0000_4000; ind_tgt = 32'h0000_5000; redir_pc = 32'h0000_6000;
    repeat (3) @(negedge clk);
    check("R1 reset fetch_pc", fetch_pc, RST_PC);
    rst_n = 1;
    m_pc = RST_PC;
    check("R1 first fetch", fetch_pc, RST_PC);
    drive(0, 0, 0, 0, 0); step();                   // R2
    check("R2 seq", fetch_pc, RST_PC + 8);
    drive(1, 1, 2, 1, 0); step();                   // R4 slot0 direct wins
    check("R3 direct tgt", fetch_pc, 32'h0000_2000);
    drive(2, 1, 3, 1, 0); step();                   // R3 return
    check("R3 ras tgt", fetch_pc, 32'h0000_4000);
    drive(3, 1, 1, 1, 0); step();                   // R3 indirect
    check("R3 ind tgt", fetch_pc, 32'h0000_5000);
    drive(1, 0, 1, 1, 0); step();                   // R6 slot1 direct
    check("R6 slot1 tgt", fetch_pc, 32'h0000_3000);
    drive(0, 1, 0, 1, 0); step();                   // R7 taken but no branch
    check("R7 ignored", fetch_pc, 32'h0000_3008);
    drive(0, 1, 2, 1, 0); step();                   // R7 slot0 non-branch, slot1 ret
    check("R7 R6 slot1 ret", fetch_pc, 32'h0000_4000);
    drive(2, 1, 3, 1, 1); step();                   // R8 redirect overrides
    check("R8 redirect", fetch_pc, 32'h0000_6000);
    // R4: slot1 changes do not affect next_pc when slot0 taken
    drive(1, 1, 3, 1, 0);
    #1; check("R4 slot1 ignored a", next_pc, 32'h0000_2000);
    s1_btb = 32'hDEAD_0000; s1_kind = 2; #1;
    check("R4 slot1 ignored b", next_pc, 32'h0000_2000);
    s1_btb = 32'h0000_3000;
    #1; step();
    // mid-run reset: R1
    rst_n = 0; @(posedge clk); @(negedge clk);
    check("R1 mid reset", fetch_pc, RST_PC);
    rst_n = 1; m_pc = RST_PC;
    for (int n = 0; n < 600; n++) begin
      drive(2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), ($urandom % 8) == 0);
      s0_btb = {$urandom} & 32'hFFFF_FFFC;
      s1_btb = {$urandom} & 32'hFFFF_FFFC;
      ras_tgt = {$urandom} & 32'hFFFF_FFFC;
      ind_tgt = {$urandom} & 32'hFFFF_FFFC;
      redir_pc = {$urandom} & 32'hFFFF_FFFC;
      step();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule